// File: doc/BRIEF.md
# Start-up Calibration Strobe Generator

After power is applied, a converter's self-calibration engine needs a long train of calibration strobes before its output can be trusted. This block produces that train without any help from software. It watches two digital health flags, one for the supply and one for the references, which come from external comparators. It also watches a run pin and an active-low chip-enable pin. It arms only when all four conditions agree and the supply flag came up strictly before the reference flag.

Once armed, the block splits time into fixed slots of converter clocks. At the start of every slot it drives a short active-low strobe. A wide counter counts the slots, and the carry-out of that counter ends the burst for good. With the default sizes, the burst gives 16384 strobes over 16 × 16384 clocks. That is about 18.3 ms at 14.3 MHz, which is far more than the worst-case number of calibration passes needs.

Dropping the run pin or deasserting chip-enable in the middle of a burst aborts it. A new burst needs the ordered power-up pattern to be seen again. A done flag reports that a complete burst has finished.

Top module: `cal_startup_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, cal_strobe_no_o is 1, busy_o is 0 and done_o is 0. Taking rst_ni low in the middle of a burst forces these values at once.
- R2: A burst starts only at a clock edge where all of the following hold together: supply_ok_i=1, ref_ok_i=1, sys_run_i=1, en_n_i=0, and the order condition of R3. busy_o is then 1 from the next cycle on. If any one of these is missing, the block stays idle.
- R3: The order condition is met once a clock edge has seen supply_ok_i=1 with ref_ok_i=0. The condition is lost whenever supply_ok_i=0. If ref_ok_i rises before supply_ok_i, or in the same cycle, no burst starts.
- R4: While busy, each slot is SLOT_LEN clocks long (default 16). cal_strobe_no_o is 0 for the first PULSE_LEN clocks of each slot (default 2) and 1 for the rest. The first slot begins in the first busy cycle. Outside a burst, cal_strobe_no_o is 1.
- R5: A complete burst holds busy_o high for exactly SLOT_LEN × 2^CNT_W cycles and gives exactly 2^CNT_W strobes. The carry-out of the CNT_W-bit slot counter (default 14) then moves the block to done, with busy_o=0 and done_o=1.
- R6: sys_run_i=0 or en_n_i=1 at an edge while busy aborts the burst. In the next cycle, busy_o=0, done_o=0 and cal_strobe_no_o=1.
- R7: Starting a burst uses up the order condition. After a burst finishes or is aborted, a new burst needs ref_ok_i=0 with supply_ok_i=1 to be seen again, followed by all the R2 conditions.
- R8: done_o stays at 1 until the next burst starts, and it is 0 from the first cycle of that new burst.
- R9: Changes of supply_ok_i and ref_ok_i during a burst neither stop it nor change its strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-above-threshold flag |
| ref_ok_i | input | 1 | Reference-span-above-threshold flag |
| sys_run_i | input | 1 | Run pin, must be high to arm or keep running |
| en_n_i | input | 1 | Active-low chip enable, must be low to arm or keep running |
| cal_strobe_no_o | output | 1 | Active-low calibration strobe |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Last burst ran to its carry-out |

## Verification
The arming logic is tested with the reference flag coming first, with both flags rising together, and with each pin condition missing in turn. Together these separate a correct order latch from one that only checks levels. One full burst runs while the health flags are pulsed. This confirms the exact strobe count and busy length, and shows that the flags have no effect once the burst is running. Aborts by the run pin, by chip-enable and by asynchronous reset are each followed by an attempt to restart without a new ordered pattern. This tells whether the order condition is consumed on arming and whether done holds until the next start.

// File: rtl/cal_startup_pkg.sv
package cal_startup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } burst_state_e;
endpackage

// File: rtl/cal_order_latch.sv
module cal_order_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic ref_ok_i,
  input  logic consume_i,
  output logic ordered_o
);
  logic ordered_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ordered_q <= 1'b0;
    else if (!supply_ok_i) ordered_q <= 1'b0;
    else if (consume_i)    ordered_q <= 1'b0;
    else if (!ref_ok_i)    ordered_q <= 1'b1;
  end

  assign ordered_o = ordered_q;

  // R3
  supply_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !ordered_o);

  // R7
  consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !ordered_o);
endmodule

// File: rtl/cal_slot_timer.sv
module cal_slot_timer #(
  parameter int SLOT_LEN  = 16,
  parameter int PULSE_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic strobe_no_o,
  output logic slot_end_o
);
  localparam int SLOT_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(SLOT_LEN - 1);
  localparam logic [SLOT_W-1:0] PULSE = SLOT_W'(PULSE_LEN);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               slot_q <= '0;
    else if (clear_i)          slot_q <= '0;
    else if (run_i) begin
      if (slot_q == LAST)      slot_q <= '0;
      else                     slot_q <= slot_q + SLOT_W'(1);
    end
  end

  assign slot_end_o  = run_i && (slot_q == LAST);
  assign strobe_no_o = !(run_i && (slot_q < PULSE));

  generate
    if (PULSE_LEN >= 2) begin : g_width_chk
      // R4
      strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(strobe_no_o) |=> (!run_i || !strobe_no_o));
    end
  endgenerate

  // R4
  slot_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end_o && !clear_i) |=> (!run_i || !strobe_no_o));
endmodule

// File: rtl/cal_burst_counter.sv
module cal_burst_counter #(
  parameter int CNT_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic carry_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= sum[CNT_W-1:0];
  end

  assign carry_o = step_i && sum[CNT_W];
endmodule

// File: rtl/cal_startup_gen.sv
module cal_startup_gen
  import cal_startup_pkg::*;
#(
  parameter int SLOT_LEN  = 16,
  parameter int PULSE_LEN = 2,
  parameter int CNT_W     = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic ref_ok_i,
  input  logic sys_run_i,
  input  logic en_n_i,
  output logic cal_strobe_no_o,
  output logic busy_o,
  output logic done_o
);
  burst_state_e state_q, state_d;
  logic ordered, pins_ok, arm, abort_run, slot_end, carry, running;

  assign pins_ok   = sys_run_i && !en_n_i;
  assign running   = (state_q == ST_RUN);
  assign arm       = !running && ordered && supply_ok_i && ref_ok_i && pins_ok;
  assign abort_run = running && !pins_ok;

  cal_order_latch u_order (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .ref_ok_i    (ref_ok_i),
    .consume_i   (arm),
    .ordered_o   (ordered)
  );

  cal_slot_timer #(.SLOT_LEN(SLOT_LEN), .PULSE_LEN(PULSE_LEN)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (arm),
    .run_i       (running),
    .strobe_no_o (cal_strobe_no_o),
    .slot_end_o  (slot_end)
  );

  cal_burst_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (arm),
    .step_i  (slot_end),
    .carry_o (carry)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (abort_run)  state_d = ST_IDLE;
        else if (carry) state_d = ST_DONE;
      end
      default: if (arm) state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = running;
  assign done_o = (state_q == ST_DONE);

  // R2
  arm_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(supply_ok_i && ref_ok_i && sys_run_i && !en_n_i));

  // R4
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_strobe_no_o |-> busy_o);

  // R5
  done_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  // R5
  excl_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R6
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (!sys_run_i || en_n_i)) |=> (!busy_o && !done_o));

  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(sys_run_i && !en_n_i && supply_ok_i && ref_ok_i)) |=> done_o);
endmodule

// File: tb/cal_startup_gen_tb_top.sv
module cal_startup_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT  = 16;
  localparam int PULSE = 2;
  localparam int CW    = 4;
  localparam int BURST = SLOT << CW;
  localparam int NSTB  = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup = 1'b0, refok = 1'b0, run = 1'b0, en_n = 1'b1;
  logic strobe_n, busy, done;

  int n_chk = 0, n_err = 0;
  int n_fall = 0, n_busy = 0;
  bit prev_stb = 1'b1;
  bit finished = 1'b0;

  // reference model state
  int  m_state = 0;  // 0 idle, 1 run, 2 done
  int  m_t = 0;
  bit  m_order = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_startup_gen #(.SLOT_LEN(SLOT), .PULSE_LEN(PULSE), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .ref_ok_i(refok),
    .sys_run_i(run), .en_n_i(en_n),
    .cal_strobe_no_o(strobe_n), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_t = 0; m_order = 1'b0;
    end else begin
      bit arm;
      arm = (m_state != 1) && m_order && sup && refok && run && !en_n;
      if (!sup)        m_order = 1'b0;
      else if (arm)    m_order = 1'b0;
      else if (!refok) m_order = 1'b1;
      if (m_state == 1) begin
        if (!run || en_n)         m_state = 0;
        else if (m_t == BURST-1)  m_state = 2;
        else                      m_t++;
      end else if (arm) begin
        m_state = 1; m_t = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_busy, e_done, e_stb;
      e_busy = (m_state == 1);
      e_done = (m_state == 2);
      e_stb  = !((m_state == 1) && ((m_t % SLOT) < PULSE));
      chk(busy == e_busy, "R2 model busy", busy, e_busy);
      chk(done == e_done, "R5 model done", done, e_done);
      chk(strobe_n == e_stb, "R4 model strobe", strobe_n, e_stb);
      if (prev_stb && !strobe_n) n_fall++;
      if (busy) n_busy++;
      prev_stb = strobe_n;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    chk(strobe_n == 1'b1, "R1 strobe in reset", strobe_n, 1);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    wait_cyc(1);
    chk(busy == 1'b0 && done == 1'b0, "R1 after release", busy, 0);

    // R3 reference first
    refok = 1'b1; wait_cyc(2);
    sup = 1'b1; run = 1'b1; en_n = 1'b0;
    wait_cyc(20);
    chk(busy == 1'b0, "R3 ref before supply", busy, 0);

    // R3 simultaneous rise
    sup = 1'b0; refok = 1'b0; wait_cyc(2);
    sup = 1'b1; refok = 1'b1; wait_cyc(20);
    chk(busy == 1'b0, "R3 simultaneous rise", busy, 0);

    // R2 missing pins
    refok = 1'b0; run = 1'b0; wait_cyc(2);
    refok = 1'b1; wait_cyc(10);
    chk(busy == 1'b0, "R2 run pin low", busy, 0);
    run = 1'b1; en_n = 1'b1; wait_cyc(10);
    chk(busy == 1'b0, "R2 enable high", busy, 0);
    n_fall = 0; n_busy = 0;
    en_n = 1'b0; wait_cyc(1);
    chk(busy == 1'b1, "R2 arm next cycle", busy, 1);

    // R9 flags toggled during burst
    wait_cyc(40);
    sup = 1'b0; refok = 1'b0; wait_cyc(5);
    sup = 1'b1; refok = 1'b1;
    for (int i = 0; i < BURST + 10 && !done; i++) wait_cyc(1);
    chk(busy == 1'b0 && done == 1'b1, "R9 burst ran to end", done, 1);
    chk(n_fall == NSTB, "R5 strobe count", n_fall, NSTB);
    chk(n_busy == BURST, "R5 busy length", n_busy, BURST);
    chk(strobe_n == 1'b1, "R5 strobe idle after done", strobe_n, 1);

    // R8 / R7 done holds, no rearm without new order
    wait_cyc(30);
    chk(done == 1'b1, "R8 done held", done, 1);
    chk(busy == 1'b0, "R7 no rearm without order", busy, 0);

    // R7 rearm, R8 done clears, R4 first pulse shape
    refok = 1'b0; wait_cyc(2);
    refok = 1'b1; wait_cyc(1);
    chk(busy == 1'b1, "R7 rearm after order", busy, 1);
    chk(done == 1'b0, "R8 done cleared on start", done, 0);
    chk(strobe_n == 1'b0, "R4 pulse cycle 1", strobe_n, 0);
    wait_cyc(1);
    chk(strobe_n == 1'b0, "R4 pulse cycle 2", strobe_n, 0);
    wait_cyc(1);
    chk(strobe_n == 1'b1, "R4 pulse end", strobe_n, 1);

    // R6 abort by enable
    wait_cyc(50);
    en_n = 1'b1; wait_cyc(1);
    chk(busy == 1'b0 && done == 1'b0, "R6 abort by enable", busy, 0);
    chk(strobe_n == 1'b1, "R6 strobe idle after abort", strobe_n, 1);
    en_n = 1'b0; wait_cyc(20);
    chk(busy == 1'b0, "R7 no rearm after abort", busy, 0);

    // R6 abort by run pin
    refok = 1'b0; wait_cyc(2);
    refok = 1'b1; wait_cyc(1);
    chk(busy == 1'b1, "R7 rearm again", busy, 1);
    wait_cyc(5);
    run = 1'b0; wait_cyc(1);
    chk(busy == 1'b0 && done == 1'b0, "R6 abort by run pin", busy, 0);

    // R1 async reset mid-burst
    run = 1'b1; refok = 1'b0; wait_cyc(2);
    refok = 1'b1; wait_cyc(3);
    chk(busy == 1'b1, "R2 arm before reset", busy, 1);
    #1 rst_n = 1'b0;
    #1;
    chk(busy == 1'b0 && done == 1'b0 && strobe_n == 1'b1, "R1 async reset", busy, 0);
    wait_cyc(2);
    summary();
  end
endmodule